// File: doc/BRIEF.md
# Compare Output Pin Driver with Force Strobe

This block drives the output pins of a set of timer compare channels. Each channel
has its own pin register. The pin changes when the channel sees a compare-match pulse
from the counter logic, or when software pulses the channel's force strobe. A 2-bit
action field for each channel decides how the pin reacts to such an event. The field
can hold the pin, toggle it, drive it low or drive it high.

The force strobe creates an immediate compare event for the pin logic. It is ignored
while the shared PWM flag is high, because waveform shaping then owns the pin. The
strobe stores nothing. The effect of a force comes only from the action field as it
stands in the cycle the strobe is high. A real match and a force in the same cycle
count as one event, so a toggle happens once. Every pin update is registered and
appears one clock after the event.

Top module: `cmpout_strobe_unit`

## Requirements
- R1: While `rst_n` is low, every pin is driven to 0 from the next clock edge on.
- R2: Action code 2'b00 (hold): an event leaves the pin at its current level.
- R3: Action code 2'b01 (toggle): an event inverts the pin one clock later.
- R4: Action code 2'b10 (clear): an event drives the pin to 0 one clock later.
- R5: Action code 2'b11 (set): an event drives the pin to 1 one clock later.
- R6: When `pwm_mode` is 0, a force strobe updates the pin exactly like a compare match, using the current action code.
- R7: When `pwm_mode` is 1, a force strobe without a match leaves the pin unchanged.
- R8: A match and a force on the same channel in the same cycle cause one update only. Under toggle, the pin inverts once.
- R9: The strobe keeps no state. In any cycle with no match and no honoured force, the pin keeps its level, whatever the action code does after an earlier force.
- R10: A compare match updates the pin whatever the value of `pwm_mode`.
- R11: Channels are independent. Channel i uses bits [2i+1:2i] of `mode_sel` and bit i of the match and force vectors, and no other channel's inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_match | input | NUM_CH | One-cycle compare-match pulse, one bit per channel |
| force_strobe | input | NUM_CH | One-cycle software force pulse, one bit per channel |
| pwm_mode | input | 1 | High while the timer runs in a PWM waveform mode |
| mode_sel | input | 2*NUM_CH | Action code per channel: 00 hold, 01 toggle, 10 clear, 11 set |
| pin_out | output | NUM_CH | Registered compare output pins |

## Verification
The bench builds the block with NUM_CH = 2. With two channels it can check isolation:
channel 1 sits on the toggle code with no events while channel 0 is exercised, and then
the roles are swapped. The bench checks every action code on both matches and forces.
It also covers the PWM gating of forces, a coincident match and force under toggle, and
a change of action code after a force, which must not disturb the pin.

// File: rtl/cmpout_pkg.sv
package cmpout_pkg;
    localparam int ACT_W = 2;

    typedef enum logic [ACT_W-1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } cmp_act_e;
endpackage

// File: rtl/cmpout_event.sv
// Merges a real compare match with a gated force strobe into one event.
module cmpout_event (
    input  logic match_i,
    input  logic force_i,
    input  logic pwm_i,
    output logic fire_o
);
    logic force_ok;

    always_comb begin
        force_ok = force_i & ~pwm_i;
        fire_o   = match_i | force_ok;
    end
endmodule

// File: rtl/cmpout_action.sv
// Next pin level for one channel from its action code.
module cmpout_action
    import cmpout_pkg::*;
(
    input  logic     fire_i,
    input  cmp_act_e act_i,
    input  logic     pin_i,
    output logic     pin_o
);
    always_comb begin
        pin_o = pin_i;
        if (fire_i) begin
            unique case (act_i)
                ACT_HOLD:   pin_o = pin_i;
                ACT_TOGGLE: pin_o = ~pin_i;
                ACT_CLEAR:  pin_o = 1'b0;
                ACT_SET:    pin_o = 1'b1;
                default:    pin_o = pin_i;
            endcase
        end
    end
endmodule

// File: rtl/cmpout_strobe_unit.sv
module cmpout_strobe_unit
    import cmpout_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       cmp_match,
    input  logic [NUM_CH-1:0]       force_strobe,
    input  logic                    pwm_mode,
    input  logic [ACT_W*NUM_CH-1:0] mode_sel,
    output logic [NUM_CH-1:0]       pin_out
);
    typedef struct packed {
        logic [NUM_CH-1:0] pin;
    } state_t;

    state_t            st_d, st_q;
    logic [NUM_CH-1:0] fire;
    logic [NUM_CH-1:0] pin_nx;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        cmp_act_e act;
        assign act = cmp_act_e'(mode_sel[i*ACT_W +: ACT_W]);

        cmpout_event u_evt (
            .match_i (cmp_match[i]),
            .force_i (force_strobe[i]),
            .pwm_i   (pwm_mode),
            .fire_o  (fire[i])
        );

        cmpout_action u_act (
            .fire_i (fire[i]),
            .act_i  (act),
            .pin_i  (st_q.pin[i]),
            .pin_o  (pin_nx[i])
        );

        AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!cmp_match[i] && !(force_strobe[i] && !pwm_mode)) |=> $stable(pin_out[i])); // R9
        AST_PWM_FORCE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            (pwm_mode && force_strobe[i] && !cmp_match[i]) |=> $stable(pin_out[i])); // R7
        AST_EVENT_SET: assert property (@(posedge clk) disable iff (!rst_n)
            ((cmp_match[i] || (force_strobe[i] && !pwm_mode)) && act == ACT_SET) |=> pin_out[i]); // R5
        AST_EVENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            ((cmp_match[i] || (force_strobe[i] && !pwm_mode)) && act == ACT_CLEAR) |=> !pin_out[i]); // R4
        AST_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (act == ACT_HOLD) |=> $stable(pin_out[i])); // R2
        AST_TOGGLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            ((cmp_match[i] || (force_strobe[i] && !pwm_mode)) && act == ACT_TOGGLE)
            |=> (pin_out[i] != $past(pin_out[i]))); // R8
    end

    always_comb begin
        st_d     = st_q;
        st_d.pin = pin_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_out = st_q.pin;

    AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> (pin_out == '0)); // R1
endmodule

// File: tb/cmpout_strobe_unit_tb_top.sv
module cmpout_strobe_unit_tb_top;
    localparam int CLK_P  = 10;
    localparam int NUM_CH = 2;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [NUM_CH-1:0]     cmp_match;
    logic [NUM_CH-1:0]     force_strobe;
    logic                  pwm_mode;
    logic [2*NUM_CH-1:0]   mode_sel;
    logic [NUM_CH-1:0]     pin_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    cmpout_strobe_unit #(.NUM_CH(NUM_CH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmp_match(cmp_match),
        .force_strobe(force_strobe), .pwm_mode(pwm_mode),
        .mode_sel(mode_sel), .pin_out(pin_out)
    );

    // Drive one cycle of stimulus at the falling edge, let the rising edge
    // register it, return to idle at the next falling edge.
    task automatic step(input logic [1:0] m, input logic [1:0] f,
                        input logic p, input logic [3:0] md);
        @(negedge clk);
        cmp_match = m; force_strobe = f; pwm_mode = p; mode_sel = md;
        @(negedge clk);
        cmp_match = '0; force_strobe = '0;
    endtask

    task automatic chk(input logic [1:0] exp, input string tag);
        n_chk++;
        if (pin_out !== exp) begin
            n_fail++;
            $display("FAIL %s: pin_out=%b expected=%b", tag, pin_out, exp);
        end
    endtask

    task automatic t_reset;
        rst_n = 0; cmp_match = '0; force_strobe = '0; pwm_mode = 0; mode_sel = 4'b0111;
        repeat (3) @(negedge clk);
        chk(2'b00, "R1 reset");
        rst_n = 1;
    endtask

    // ch1 held on toggle (01) with no events throughout: R11
    task automatic t_codes;
        step(2'b01, 2'b00, 0, 4'b0111); chk(2'b01, "R5 set on match");
        step(2'b01, 2'b00, 0, 4'b0100); chk(2'b01, "R2 hold on match");
        step(2'b01, 2'b00, 0, 4'b0110); chk(2'b00, "R4 clear on match");
        step(2'b01, 2'b00, 0, 4'b0101); chk(2'b01, "R3 toggle to 1");
        step(2'b01, 2'b00, 0, 4'b0101); chk(2'b00, "R3 toggle to 0");
    endtask

    task automatic t_force;
        step(2'b00, 2'b01, 0, 4'b0111); chk(2'b01, "R6 force set");
        step(2'b00, 2'b01, 0, 4'b0100); chk(2'b01, "R6 force hold");
        step(2'b00, 2'b01, 0, 4'b0110); chk(2'b00, "R6 force clear");
    endtask

    task automatic t_pwm;
        step(2'b00, 2'b01, 1, 4'b0111); chk(2'b00, "R7 force ignored in pwm");
        step(2'b00, 2'b01, 1, 4'b0101); chk(2'b00, "R7 force toggle ignored in pwm");
        step(2'b01, 2'b00, 1, 4'b0111); chk(2'b01, "R10 match honoured in pwm");
    endtask

    task automatic t_both;
        step(2'b01, 2'b01, 0, 4'b0101); chk(2'b00, "R8 match+force toggles once");
        step(2'b01, 2'b01, 0, 4'b0101); chk(2'b01, "R8 match+force toggles once again");
    endtask

    task automatic t_no_state;
        step(2'b00, 2'b01, 0, 4'b0101); chk(2'b00, "R9 force toggle");
        step(2'b00, 2'b00, 0, 4'b0111); chk(2'b00, "R9 no replay under set");
        step(2'b00, 2'b00, 0, 4'b0101); chk(2'b00, "R9 no replay under toggle");
        step(2'b00, 2'b00, 0, 4'b0110); chk(2'b00, "R9 no replay under clear");
    endtask

    task automatic t_isolation;
        step(2'b10, 2'b00, 0, 4'b0101); chk(2'b10, "R11 ch1 match only");
        step(2'b00, 2'b10, 0, 4'b1101); chk(2'b10, "R11 ch1 force set, ch0 idle");
        step(2'b01, 2'b00, 0, 4'b0011); chk(2'b11, "R11 ch0 set, ch1 hold");
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_codes();
        t_force();
        t_pwm();
        t_both();
        t_no_state();
        t_isolation();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule